// File: doc/BRIEF.md
# Pulse-Interrupted Cell Balancing Controller

This controller manages passive balancing of a two-cell series stack. It counts whole seconds while idle. When a programmable number of seconds has passed, it runs one balancing round. The round asserts a charge-pause override, opens both bypass shunts and discards the previous decision. It then waits a settling delay so that the voltage drop across the cells' internal impedance dies away, and asks an external converter for fresh readings of both cells.

When the readings arrive, the block applies one of two decision rules, chosen by the charge or discharge phase. If the rule asks for balancing, it closes the bypass of the higher cell. It then releases the charge pause and waits a trailing delay before idle counting starts again. The decision holds until the next round begins.

A separate reset request returns the block to idle with both shunts open and the pause released. The surrounding charger raises this request when it enters charge complete, fault or full discharge.

Top module: `cell_bal_ctrl`

## Requirements
- R1: While idle, the block raises `chg_pause` on the second-boundary clock edge at which the count of idle seconds reaches `cfg_interval`. A value of 0 acts as 1. A second boundary is every `CLKS_PER_SEC`-th clock from reset.
- R2: On the edge that raises `chg_pause`, both bypass outputs go low. `meas_req` rises `cfg_start_dly`+1 clock cycles after `chg_pause` rises, and `chg_pause` stays high while `meas_req` is high.
- R3: In the charge phase (`dis_phase`=0), balancing is requested when the higher cell code minus the lower exceeds `cfg_min_chg` strictly. A difference equal to the limit does not balance.
- R4: In the charge phase, no balancing occurs when `cv_mode`=1 and `chg_cur` < `cfg_min_cur`. The current gate has no effect when `cv_mode`=0.
- R5: In the discharge phase (`dis_phase`=1), balancing is requested only when the difference exceeds `cfg_min_dis` strictly and the higher cell code is at or above `cfg_vmid`. `cv_mode` and `chg_cur` are ignored in this phase.
- R6: When balancing is requested, `byp1` goes high if `v_cell1` > `v_cell2`, otherwise `byp2` goes high. Equal codes never balance. The decision appears on the edge after the one that samples `meas_done` high in the measuring step, and it holds until the next round starts.
- R7: `byp1` and `byp2` are active-high and never both high.
- R8: Reset (`rst_n`=0) or a sampled `bal_reset`=1 clears both bypasses, `chg_pause` and `meas_req` on the next edge and returns the block to idle with the second count cleared.
- R9: `chg_pause` falls on the decision edge. Idle second counting restarts only after a trailing wait of `cfg_end_dly`+1 cycles.
- R10: `meas_req` stays high until `meas_done` is sampled high, and it drops on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bal_reset | input | 1 | Synchronous request to abort and open both shunts |
| dis_phase | input | 1 | 1 = discharge phase rules, 0 = charge phase rules |
| cv_mode | input | 1 | Charger is in constant-voltage mode |
| v_cell1 | input | VW | Voltage code of cell 1 |
| v_cell2 | input | VW | Voltage code of cell 2 |
| chg_cur | input | IW | Charge current code |
| cfg_interval | input | SW | Seconds between rounds |
| cfg_start_dly | input | DW | Settling wait before measuring, in cycles minus one |
| cfg_end_dly | input | DW | Trailing wait after deciding, in cycles minus one |
| cfg_min_chg | input | VW | Charge-phase imbalance threshold |
| cfg_min_dis | input | VW | Discharge-phase imbalance threshold |
| cfg_min_cur | input | IW | Lowest current that permits balancing in CV mode |
| cfg_vmid | input | VW | Mid-charge voltage gate for discharge balancing |
| meas_done | input | 1 | Fresh cell readings are valid |
| meas_req | output | 1 | Request for a measurement of both cells |
| chg_pause | output | 1 | Charge current override (1 = suspend charging) |
| byp1 | output | 1 | Cell 1 shunt switch, high = closed |
| byp2 | output | 1 | Cell 2 shunt switch, high = closed |

## Verification
Every output is registered or decoded from state. A stimulus sampled on one rising edge therefore shows at the ports on that same edge and is read at the following falling edge.

- The pause rises on the second-boundary edge that completes the interval.
- `meas_req` follows `cfg_start_dly`+1 edges later.
- The bypass choice and the pause release appear on the edge after `meas_done` is seen.
- A reset request clears the outputs on the first edge that samples it.

A behavioural reference model advances on the same rising edges and is compared at every falling edge. Per-case checks read the bypass pair right after the pause falls. The checks also measure the idle gap between rounds against the window that the trailing delay and the prescaler phase allow.

// File: rtl/cell_bal_ctrl.sv
module cell_bal_ctrl #(
  parameter int VW = 12,
  parameter int IW = 12,
  parameter int SW = 8,
  parameter int DW = 8,
  parameter int CLKS_PER_SEC = 50_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bal_reset,
  input  logic          dis_phase,
  input  logic          cv_mode,
  input  logic [VW-1:0] v_cell1,
  input  logic [VW-1:0] v_cell2,
  input  logic [IW-1:0] chg_cur,
  input  logic [SW-1:0] cfg_interval,
  input  logic [DW-1:0] cfg_start_dly,
  input  logic [DW-1:0] cfg_end_dly,
  input  logic [VW-1:0] cfg_min_chg,
  input  logic [VW-1:0] cfg_min_dis,
  input  logic [IW-1:0] cfg_min_cur,
  input  logic [VW-1:0] cfg_vmid,
  input  logic          meas_done,
  output logic          meas_req,
  output logic          chg_pause,
  output logic          byp1,
  output logic          byp2
);

  localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_SEC - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_MEAS, S_END} st_t;

  st_t st;
  logic [PW-1:0] pre;
  logic [SW-1:0] secs;
  logic [DW-1:0] dcnt;

  wire          sec_tick = (pre == PRE_LAST);
  wire [SW:0]   secs_nx  = {1'b0, secs} + {{SW{1'b0}}, 1'b1};
  wire          due      = secs_nx >= {1'b0, cfg_interval};

  wire          c1_hi = v_cell1 > v_cell2;
  wire [VW-1:0] hi    = c1_hi ? v_cell1 : v_cell2;
  wire [VW-1:0] lo    = c1_hi ? v_cell2 : v_cell1;
  wire [VW-1:0] diff  = hi - lo;
  wire          cv_block = cv_mode && (chg_cur < cfg_min_cur);
  wire          chg_ok   = !dis_phase && (diff > cfg_min_chg) && !cv_block;
  wire          dis_ok   = dis_phase && (diff > cfg_min_dis) && (hi >= cfg_vmid);
  wire          want     = chg_ok || dis_ok;

  assign meas_req = (st == S_MEAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= sec_tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; secs <= '0; dcnt <= '0;
      chg_pause <= 1'b0; byp1 <= 1'b0; byp2 <= 1'b0;
    end else if (bal_reset) begin
      st <= S_IDLE; secs <= '0; dcnt <= '0;
      chg_pause <= 1'b0; byp1 <= 1'b0; byp2 <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (sec_tick) begin
          if (due) begin
            st <= S_START; secs <= '0; dcnt <= cfg_start_dly;
            chg_pause <= 1'b1; byp1 <= 1'b0; byp2 <= 1'b0;
          end else begin
            secs <= secs_nx[SW-1:0];
          end
        end
        S_START: if (dcnt == '0) st <= S_MEAS;
                 else dcnt <= dcnt - 1'b1;
        S_MEAS: if (meas_done) begin
          st <= S_END; dcnt <= cfg_end_dly; chg_pause <= 1'b0;
          byp1 <= want && c1_hi;
          byp2 <= want && !c1_hi;
        end
        S_END: if (dcnt == '0) st <= S_IDLE;
               else dcnt <= dcnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_one_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !(byp1 && byp2));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bal_reset |=> (!byp1 && !byp2 && !chg_pause && !meas_req));

  a_r2_open_on_pause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_pause) |-> (!byp1 && !byp2));

  a_r2_req_paused: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> chg_pause);

  a_r6_close_on_decision: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(byp1) || $rose(byp2)) |-> $past(meas_req && meas_done));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && meas_done && !bal_reset) |=> (!chg_pause && !meas_req));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !meas_done && !bal_reset) |=> meas_req);

endmodule

// File: tb/sim_cell_bal_ctrl.sv
`timescale 1ns/1ps
module sim_cell_bal_ctrl;
  localparam int CPS = 5;
  localparam int INT = 2;
  localparam int SD  = 3;
  localparam int ED  = 2;

  logic clk = 0, rst_n = 0, bal_reset = 0, dis_phase = 0, cv_mode = 0, meas_done = 0;
  logic [11:0] v_cell1 = 0, v_cell2 = 0, chg_cur = 0;
  logic [11:0] cfg_min_chg = 20, cfg_min_dis = 40, cfg_min_cur = 100, cfg_vmid = 3600;
  logic [7:0]  cfg_interval = INT, cfg_start_dly = SD, cfg_end_dly = ED;
  logic meas_req, chg_pause, byp1, byp2;

  int checks = 0, fails = 0, cyc = 0, ack_cnt = 0;

  cell_bal_ctrl #(.VW(12), .IW(12), .SW(8), .DW(8), .CLKS_PER_SEC(CPS)) u0 (
    .clk(clk), .rst_n(rst_n), .bal_reset(bal_reset), .dis_phase(dis_phase),
    .cv_mode(cv_mode), .v_cell1(v_cell1), .v_cell2(v_cell2), .chg_cur(chg_cur),
    .cfg_interval(cfg_interval), .cfg_start_dly(cfg_start_dly),
    .cfg_end_dly(cfg_end_dly), .cfg_min_chg(cfg_min_chg), .cfg_min_dis(cfg_min_dis),
    .cfg_min_cur(cfg_min_cur), .cfg_vmid(cfg_vmid), .meas_done(meas_done),
    .meas_req(meas_req), .chg_pause(chg_pause), .byp1(byp1), .byp2(byp2));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // behavioural reference model
  int m_ph = 0, m_sec = 0, m_wait = 0, m_pre = 0;
  bit m_pause = 0, m_b1 = 0, m_b2 = 0;

  function automatic bit decide(input int a, input int b, input bit dis, input bit cv, input int cur);
    int d, top;
    d   = (a > b) ? a - b : b - a;
    top = (a > b) ? a : b;
    if (dis) return (d > cfg_min_dis) && (top >= cfg_vmid);
    return (d > cfg_min_chg) && !(cv && cur < cfg_min_cur);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_sec = 0; m_wait = 0; m_pre = 0; m_pause = 0; m_b1 = 0; m_b2 = 0;
    end else begin
      bit tick;
      tick = (m_pre == CPS - 1);
      m_pre = tick ? 0 : m_pre + 1;
      if (bal_reset) begin
        m_ph = 0; m_sec = 0; m_wait = 0; m_pause = 0; m_b1 = 0; m_b2 = 0;
      end else if (m_ph == 0) begin
        if (tick) begin
          if (m_sec + 1 >= int'(cfg_interval)) begin
            m_ph = 1; m_sec = 0; m_wait = cfg_start_dly; m_pause = 1; m_b1 = 0; m_b2 = 0;
          end else m_sec++;
        end
      end else if (m_ph == 1) begin
        if (m_wait == 0) m_ph = 2; else m_wait--;
      end else if (m_ph == 2) begin
        if (meas_done) begin
          bit w;
          w = decide(v_cell1, v_cell2, dis_phase, cv_mode, chg_cur);
          m_ph = 3; m_wait = cfg_end_dly; m_pause = 0;
          m_b1 = w && (v_cell1 > v_cell2);
          m_b2 = w && !(v_cell1 > v_cell2);
        end
      end else begin
        if (m_wait == 0) m_ph = 0; else m_wait--;
      end
    end
  end

  // measurement responder: acknowledges two cycles after a request appears
  always @(posedge clk) begin
    #1;
    if (meas_req && !meas_done) begin
      if (ack_cnt == 1) begin meas_done = 1; ack_cnt = 0; end
      else ack_cnt++;
    end else begin
      meas_done = 0;
      if (!meas_req) ack_cnt = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      finish_run();
    end
  end

  // per-cycle comparison and idle-gap monitor
  bit prev_pause = 0, prev_md = 0;
  int fell_at = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(chg_pause == m_pause, "R1 chg_pause vs model", chg_pause, m_pause);
      chk(meas_req == (m_ph == 2), "R2 meas_req vs model", meas_req, m_ph == 2);
      chk(byp1 == m_b1, "R6 byp1 vs model", byp1, m_b1);
      chk(byp2 == m_b2, "R6 byp2 vs model", byp2, m_b2);
      chk(!(byp1 && byp2), "R7 one bypass", byp1 + byp2, 1);
      if (prev_pause && !chg_pause) fell_at = prev_md ? cyc : -1;
      if (bal_reset) fell_at = -1;
      if (!prev_pause && chg_pause && fell_at >= 0) begin
        int g;
        g = cyc - fell_at;
        chk(g >= ED + 2 + (INT - 1) * CPS && g <= ED + 1 + INT * CPS,
            "R9 idle gap after release", g, ED + 1 + INT * CPS);
      end
      prev_pause = chg_pause;
      prev_md = meas_req && meas_done;
    end
  end

  task automatic do_case(input int a, input int b, input bit dis, input bit cv,
                         input int cur, input bit e1, input bit e2, input string tag);
    @(posedge clk); #2;
    v_cell1 = a[11:0]; v_cell2 = b[11:0]; dis_phase = dis; cv_mode = cv; chg_cur = cur[11:0];
    @(posedge chg_pause);
    @(negedge chg_pause);
    @(negedge clk);
    chk(byp1 == e1, {tag, " byp1"}, byp1, e1);
    chk(byp2 == e2, {tag, " byp2"}, byp2, e2);
  endtask

  task automatic pulse_reset();
    @(posedge clk); #2 bal_reset = 1;
    @(posedge clk); #2 bal_reset = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!byp1 && !byp2 && !chg_pause && !meas_req, "R8 reset state",
        {byp1, byp2, chg_pause, meas_req}, 0);

    do_case(3000, 2970, 0, 0, 0,   1, 0, "R3 charge above limit, cell1 high");
    do_case(2970, 3000, 0, 0, 0,   0, 1, "R6 charge, cell2 high");
    do_case(3000, 2980, 0, 0, 0,   0, 0, "R3 difference equal to limit");
    do_case(3000, 3000, 0, 0, 0,   0, 0, "R6 equal cells");
    do_case(3000, 2950, 0, 1, 50,  0, 0, "R4 CV low current blocks");
    do_case(3000, 2950, 0, 1, 100, 1, 0, "R4 CV current at limit");
    do_case(3000, 2950, 0, 0, 50,  1, 0, "R4 low current outside CV");
    do_case(3700, 3670, 1, 0, 0,   0, 0, "R5 discharge small difference");
    do_case(3700, 3650, 1, 0, 0,   1, 0, "R5 discharge above limit");
    do_case(3550, 3600, 1, 0, 0,   0, 1, "R5 higher cell at mid gate");
    do_case(3550, 3599, 1, 0, 0,   0, 0, "R5 higher cell below mid gate");
    do_case(3700, 3650, 1, 1, 0,   1, 0, "R5 CV gate ignored in discharge");

    pulse_reset();
    @(negedge clk);
    chk(!byp1 && !byp2 && !chg_pause, "R8 reset opens closed bypass",
        {byp1, byp2, chg_pause}, 0);

    @(posedge chg_pause);
    pulse_reset();
    @(negedge clk);
    chk(!chg_pause && !meas_req, "R8 reset during settling",
        {chg_pause, meas_req}, 0);

    do_case(2900, 2950, 0, 0, 0,   0, 1, "R10 round after abort");
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule